// File: doc/BRIEF.md
# Four-Lane Word Shuffle Unit

This unit rearranges the 32-bit lanes of a 128-bit register under an 8-bit control byte. The control byte holds one 2-bit selector for each destination lane. Each selector names the source lane whose word lands in that slot.

The two low destination lanes take their words from operand A. The two high destination lanes take theirs from operand B. When both operands carry the same register, every destination lane can reach every source lane. A single control byte then produces broadcasts, reversals and arbitrary permutations.

Words move as opaque bit patterns, so floating-point encodings are not interpreted. The result and its valid flag leave through one registered stage.

Top module: `shuf_lane_permute`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and result_o is all zeros.
- R2: valid_o equals the valid_i value sampled at the previous rising clock edge.
- R3: Lane k occupies bits [32k+31:32k]. The selector for destination lane k is imm_i[2k+1:2k]. Destination lanes 0 and 1 copy the operand A lane named by their selector, and destination lanes 2 and 3 copy the named operand B lane. The result is taken from the inputs sampled at the edge where valid_i is 1.
- R4: With both operands equal, control 0x00 puts source lane 0 in every destination lane, and control 0xFF puts source lane 3 in every destination lane.
- R5: With both operands equal, control 0x17 gives destination lane 0 = source lane 3, destination lanes 1 and 2 = source lane 1, and destination lane 3 = source lane 0.
- R6: Word bit patterns pass unchanged, including NaN, infinity and denormal encodings and the all-ones word.
- R7: On an edge where valid_i is 0, result_o keeps its value whatever the operands and control carry.
- R8: R3 holds for all 256 control values, both with independent operands and with equal operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and control are valid |
| imm_i | input | 8 | Four 2-bit destination lane selectors |
| src_a_i | input | 128 | Operand A, feeds destination lanes 0 and 1 |
| src_b_i | input | 128 | Operand B, feeds destination lanes 2 and 3 |
| valid_o | output | 1 | Result is valid |
| result_o | output | 128 | Permuted result |

## Verification
A wrong selector-to-lane binding is the hardest fault to expose. It escapes detection whenever neighbouring lanes carry equal words, or when the fields of the control byte agree with each other. The stimulus therefore fills every lane with a distinct random word. It sweeps all 256 control bytes twice, once with independent operands and once with equal operands, so that every field value meets every lane position. Idle cycles with fresh data on the inputs show whether the result register holds when valid is low.

// File: rtl/shuf_pkg.sv
package shuf_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 32;
endpackage

// File: rtl/shuf_sel_decode.sv
module shuf_sel_decode #(
  parameter int unsigned LANES = shuf_pkg::LANES_DEF,
  localparam int unsigned SEL_W = $clog2(LANES),
  localparam int unsigned IMM_W = LANES * SEL_W
) (
  input  logic [IMM_W-1:0]            imm_i,
  output logic [LANES-1:0][LANES-1:0] sel_oh_o
);
  for (genvar d = 0; d < LANES; d++) begin : g_dst
    always_comb begin
      sel_oh_o[d] = '0;
      for (int s = 0; s < LANES; s++) begin
        if (imm_i[d*SEL_W +: SEL_W] == SEL_W'(s)) sel_oh_o[d][s] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/shuf_lane_xbar.sv
module shuf_lane_xbar #(
  parameter int unsigned LANES  = shuf_pkg::LANES_DEF,
  parameter int unsigned LANE_W = shuf_pkg::LANE_W_DEF,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned HALF   = LANES / 2
) (
  input  logic [DATA_W-1:0]           src_a_i,
  input  logic [DATA_W-1:0]           src_b_i,
  input  logic [LANES-1:0][LANES-1:0] sel_oh_i,
  output logic [DATA_W-1:0]           data_o
);
  for (genvar d = 0; d < LANES; d++) begin : g_dst
    logic [DATA_W-1:0] op;
    // low half of destination draws from A, high half from B
    if (d < HALF) begin : g_lo
      assign op = src_a_i;
    end else begin : g_hi
      assign op = src_b_i;
    end
    always_comb begin
      data_o[d*LANE_W +: LANE_W] = '0;
      for (int s = 0; s < LANES; s++) begin
        if (sel_oh_i[d][s]) data_o[d*LANE_W +: LANE_W] = data_o[d*LANE_W +: LANE_W] | op[s*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/shuf_out_reg.sv
module shuf_out_reg #(
  parameter int unsigned DATA_W = shuf_pkg::LANES_DEF * shuf_pkg::LANE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/shuf_lane_permute.sv
module shuf_lane_permute #(
  parameter int unsigned LANES  = shuf_pkg::LANES_DEF,
  parameter int unsigned LANE_W = shuf_pkg::LANE_W_DEF,
  localparam int unsigned SEL_W  = $clog2(LANES),
  localparam int unsigned IMM_W  = LANES * SEL_W,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic [LANES-1:0][LANES-1:0] sel_oh;
  logic [DATA_W-1:0]           xbar_data;

  shuf_sel_decode #(.LANES(LANES)) i_decode (
    .imm_i    (imm_i),
    .sel_oh_o (sel_oh)
  );

  shuf_lane_xbar #(.LANES(LANES), .LANE_W(LANE_W)) i_xbar (
    .src_a_i  (src_a_i),
    .src_b_i  (src_b_i),
    .sel_oh_i (sel_oh),
    .data_o   (xbar_data)
  );

  shuf_out_reg #(.DATA_W(DATA_W)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (xbar_data),
    .valid_o (valid_o),
    .data_o  (result_o)
  );
endmodule

// File: rtl/shuf_lane_permute_chk.sv
module shuf_lane_permute_chk #(
  parameter int unsigned LANES  = shuf_pkg::LANES_DEF,
  parameter int unsigned LANE_W = shuf_pkg::LANE_W_DEF,
  localparam int unsigned SEL_W  = $clog2(LANES),
  localparam int unsigned IMM_W  = LANES * SEL_W,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o); // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> $stable(result_o)); // R7

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k < LANES / 2) begin : g_a
      AST_LANE_FROM_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> result_o[k*LANE_W +: LANE_W] == $past(src_a_i[imm_i[k*SEL_W +: SEL_W]*LANE_W +: LANE_W])); // R3
    end else begin : g_b
      AST_LANE_FROM_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> result_o[k*LANE_W +: LANE_W] == $past(src_b_i[imm_i[k*SEL_W +: SEL_W]*LANE_W +: LANE_W])); // R3
    end
  end
endmodule

bind shuf_lane_permute shuf_lane_permute_chk #(.LANES(LANES), .LANE_W(LANE_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .imm_i    (imm_i),
  .src_a_i  (src_a_i),
  .src_b_i  (src_b_i),
  .valid_o  (valid_o),
  .result_o (result_o)
);

// File: tb/test_shuf_lane_permute.sv
module test_shuf_lane_permute;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [7:0]   imm_i = '0;
  logic [127:0] src_a_i = '0;
  logic [127:0] src_b_i = '0;
  logic         valid_o;
  logic [127:0] result_o;

  int checks = 0;
  int errors = 0;
  logic [127:0] exp_res = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  shuf_lane_permute i_shuf_lane_permute (.*);

  function automatic logic [127:0] ref_shuf(logic [127:0] a, logic [127:0] b, logic [7:0] imm);
    logic [127:0] r;
    for (int d = 0; d < 4; d++) begin
      int s = int'(imm[2*d +: 2]);
      r[32*d +: 32] = (d < 2) ? a[32*s +: 32] : b[32*s +: 32];
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic v, logic [7:0] imm, logic [127:0] a, logic [127:0] b);
    @(negedge clk_i);
    valid_i = v; imm_i = imm; src_a_i = a; src_b_i = b;
    if (v) exp_res = ref_shuf(a, b, imm);
    @(posedge clk_i); #1;
    check("R2 valid", {127'd0, valid_o}, {127'd0, v});
    check(req, result_o, exp_res);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] x;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 reset valid", {127'd0, valid_o}, 128'd0);
    check("R1 reset result", result_o, 128'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    x = {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};
    step("R4 bcast0", 1'b1, 8'h00, x, x);
    check("R4 bcast0 lane", result_o, {4{32'hAAAA_0000}});
    step("R4 bcast3", 1'b1, 8'hFF, x, x);
    check("R4 bcast3 lane", result_o, {4{32'hDDDD_0003}});
    step("R5 0x17", 1'b1, 8'h17, x, x);
    check("R5 0x17 lanes", result_o, {32'hAAAA_0000, 32'hBBBB_0001, 32'hBBBB_0001, 32'hDDDD_0003});
    step("R3 reverse", 1'b1, 8'h1B, x, x);
    check("R3 reverse lanes", result_o, {32'hAAAA_0000, 32'hBBBB_0001, 32'hCCCC_0002, 32'hDDDD_0003});

    // float specials: qNaN, sNaN, -inf, denormal
    x = {32'h7FC0_0001, 32'h7F80_0001, 32'hFF80_0000, 32'h0000_0001};
    step("R6 specials", 1'b1, 8'hE4, x, x);
    check("R6 identity", result_o, x);
    step("R6 ones", 1'b1, 8'h4E, {128{1'b1}}, 128'd0);
    check("R6 ones lanes", result_o, {64'd0, 64'hFFFF_FFFF_FFFF_FFFF});

    // idle with fresh inputs must not disturb result
    for (int i = 0; i < 8; i++) step("R7 hold", 1'b0, 8'($urandom()), rnd128(), rnd128());
    step("R2 resume", 1'b1, 8'h93, rnd128(), rnd128());

    for (int i = 0; i < 256; i++) step("R8 indep", 1'b1, 8'(i), rnd128(), rnd128());
    for (int i = 0; i < 256; i++) begin
      x = rnd128();
      step("R8 equal", 1'b1, 8'(i), x, x);
      if (($urandom() & 3) == 0) step("R7 hold mixed", 1'b0, 8'(i), rnd128(), rnd128());
    end

    @(negedge clk_i); rst_ni = 1'b0; #1;
    check("R1 async reset valid", {127'd0, valid_o}, 128'd0);
    check("R1 async reset result", result_o, 128'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule